// File: doc/BRIEF.md
# Polynomial Scaling and Shift Unit over GF(2^11)

This unit takes a polynomial B(z) with 27 coefficients in GF(2^11) and, in one clock cycle, either multiplies every coefficient by a single field element, or multiplies the whole polynomial by z modulo a monic degree-27 Goppa polynomial G(z). A bank of 27 combinational bit-level field multipliers serves both operations. Each multiplier is an XOR network reduced by the field polynomial x^11 + x^2 + 1, with no lookup tables. In scaling mode, each multiplier takes the scalar and one coefficient of B. In shift mode, the coefficient that leaves the top of B is routed on its own path to act as the scalar for the bank, which then multiplies the low coefficients of G. The unit is meant as the inner step of larger polynomial arithmetic in a Goppa decoder.

A result is written into the output register only on a cycle where the input is marked valid. The output valid flag follows one cycle later.

Top module: `gf11_poly_scaler`

## Requirements
- R1: Field products use polynomial basis, with bit j of an 11-bit value being the coefficient of x^j, and are reduced by x^11 + x^2 + 1. For example, 0x400 times 0x002 gives 0x005.
- R2: Polynomials are packed with coefficient i in bits [11*i+10 : 11*i]. In scaling mode (shift_mode = 0), output coefficient i equals scalar times B coefficient i, for every i from 0 to 26.
- R3: A result accepted with in_valid high appears on poly_c at the next rising clock edge, and out_valid is high in that same cycle.
- R4: When in_valid is low at a clock edge, poly_c keeps its value and out_valid is low in the following cycle.
- R5: In scaling mode, a zero scalar gives the all-zero polynomial.
- R6: In shift mode (shift_mode = 1), output coefficient i equals B coefficient i-1 plus b26 times g_i, and output coefficient 0 equals b26 times g_0. Here goppa_low carries g_0..g_26 of the monic G(z), and b26 is the top coefficient of B.
- R7: In shift mode with b26 equal to zero, the output is B moved up by one coefficient position, with zero in coefficient 0.
- R8: In scaling mode, a scalar of 1 returns B unchanged.
- R9: After reset, out_valid is low and poly_c is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operands valid; result register loads |
| shift_mode | input | 1 | 0: scale by scalar, 1: multiply by z mod G |
| scalar | input | 11 | Field element used in scaling mode |
| poly_b | input | 297 | Operand polynomial, 27 coefficients |
| goppa_low | input | 297 | Coefficients g_0..g_26 of monic G(z) |
| out_valid | output | 1 | Result valid |
| poly_c | output | 297 | Registered result polynomial |

## Verification
A fault in one field multiplier, or a wrong reduction tap, shows up as a single wrong 11-bit slice of poly_c. This appears in the cycle right after the operands are accepted, and only for operand values that reach the faulty bit, so random operands are mixed with reduction-heavy ones such as 0x400. A fault in the top-coefficient path shows only in shift mode with a nonzero b26. A fault in the load enable shows as poly_c changing, or out_valid staying high, in the first idle cycle after an operation.

// File: rtl/gf11_poly_scaler.sv
module gf11_poly_scaler #(
  parameter int M = 11,
  parameter int T = 27,
  parameter logic [M-1:0] FIELD_LOW = 11'h005
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic           shift_mode,
  input  logic [M-1:0]   scalar,
  input  logic [T*M-1:0] poly_b,
  input  logic [T*M-1:0] goppa_low,
  output logic           out_valid,
  output logic [T*M-1:0] poly_c
);

  localparam int W  = T * M;
  localparam int PW = 2 * M - 1;
  localparam logic [PW-1:0] RED = PW'({1'b1, FIELD_LOW});

  function automatic logic [M-1:0] gf_mul(input logic [M-1:0] x, input logic [M-1:0] y);
    logic [PW-1:0] p;
    p = '0;
    for (int i = 0; i < M; i++)
      if (y[i]) p = p ^ (PW'(x) << i);
    for (int k = PW - 1; k >= M; k--)
      if (p[k]) p = p ^ (RED << (k - M));
    return p[M-1:0];
  endfunction

  logic [M-1:0] top_coef;
  logic [M-1:0] op_x;
  logic [W-1:0] next_c;

  assign top_coef = poly_b[W-1 -: M];
  assign op_x     = shift_mode ? top_coef : scalar;

  for (genvar i = 0; i < T; i++) begin : g_bank
    logic [M-1:0] op_y;
    logic [M-1:0] carry_in;
    assign op_y = shift_mode ? goppa_low[i*M +: M] : poly_b[i*M +: M];
    if (i == 0) begin : g_low
      assign carry_in = '0;
    end else begin : g_up
      assign carry_in = shift_mode ? poly_b[(i-1)*M +: M] : '0;
    end
    assign next_c[i*M +: M] = gf_mul(op_x, op_y) ^ carry_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      poly_c    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) poly_c <= next_c;
    end
  end

  p_valid_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(poly_c) && !out_valid));

  p_zero_scalar_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !shift_mode && scalar == '0) |=> (poly_c == '0));

  p_plain_shift_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && shift_mode && top_coef == '0) |=>
      (poly_c == {$past(poly_b[W-M-1:0]), {M{1'b0}}}));

  p_unit_scalar_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !shift_mode && scalar == M'(1)) |=> (poly_c == $past(poly_b)));

  p_top_into_g_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && shift_mode && top_coef == M'(1)) |=>
      (poly_c == ({$past(poly_b[W-M-1:0]), {M{1'b0}}} ^ $past(goppa_low))));

endmodule

// File: tb/gf11_poly_scaler_bench.sv
module gf11_poly_scaler_bench;
  localparam int M = 11;
  localparam int T = 27;
  localparam int W = T * M;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic shift_mode = 1'b0;
  logic [M-1:0] scalar = '0;
  logic [W-1:0] poly_b = '0;
  logic [W-1:0] goppa_low = '0;
  logic out_valid;
  logic [W-1:0] poly_c;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gf11_poly_scaler u_gf11_poly_scaler (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .shift_mode(shift_mode),
    .scalar(scalar), .poly_b(poly_b), .goppa_low(goppa_low),
    .out_valid(out_valid), .poly_c(poly_c)
  );

  function automatic logic [M-1:0] ref_mul(input logic [M-1:0] x, input logic [M-1:0] y);
    logic [M-1:0] acc;
    logic [M-1:0] sh;
    acc = '0;
    sh = x;
    for (int i = 0; i < M; i++) begin
      if (y[i]) acc = acc ^ sh;
      sh = sh[M-1] ? ({sh[M-2:0], 1'b0} ^ 11'h005) : {sh[M-2:0], 1'b0};
    end
    return acc;
  endfunction

  function automatic logic [W-1:0] ref_scale(input logic [M-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] r;
    for (int i = 0; i < T; i++) r[i*M +: M] = ref_mul(a, b[i*M +: M]);
    return r;
  endfunction

  function automatic logic [W-1:0] ref_shift(input logic [W-1:0] b, input logic [W-1:0] g);
    logic [W-1:0] r;
    logic [M-1:0] top;
    top = b[W-1 -: M];
    for (int i = 0; i < T; i++)
      r[i*M +: M] = ref_mul(top, g[i*M +: M]) ^ ((i > 0) ? b[(i-1)*M +: M] : '0);
    return r;
  endfunction

  function automatic logic [W-1:0] rand_poly();
    logic [W-1:0] r;
    for (int i = 0; i < T; i++) r[i*M +: M] = M'($urandom() % 2048);
    return r;
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_op(input string req, input logic m, input logic [M-1:0] a,
                        input logic [W-1:0] b, input logic [W-1:0] g);
    logic [W-1:0] exp;
    logic [W-1:0] held;
    exp = m ? ref_shift(b, g) : ref_scale(a, b);
    @(negedge clk);
    shift_mode = m; scalar = a; poly_b = b; goppa_low = g; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R3 valid", W'(out_valid), W'(1));
    chk(req, poly_c, exp);
    held = poly_c;
    shift_mode = ~m; scalar = M'($urandom() % 2048); poly_b = rand_poly(); goppa_low = rand_poly();
    @(negedge clk);
    chk("R4 hold", poly_c, held);
    chk("R4 valid low", W'(out_valid), W'(0));
  endtask

  initial begin
    int unsigned seed_init;
    logic [W-1:0] b;
    logic [W-1:0] g;
    seed_init = $urandom(32'd4711);
    repeat (3) @(negedge clk);
    chk("R9 reset data", poly_c, '0);
    chk("R9 reset valid", W'(out_valid), W'(0));
    rst_n = 1'b1;

    b = '0; b[10:0] = 11'h002;
    run_op("R1 reduction", 1'b0, 11'h400, b, rand_poly());
    chk("R1 known product", W'(poly_c[10:0]), W'(11'h005));

    run_op("R5 zero scalar", 1'b0, '0, rand_poly(), rand_poly());
    b = rand_poly();
    run_op("R8 unit scalar", 1'b0, 11'h001, b, rand_poly());
    chk("R8 identity", poly_c, b);

    b = rand_poly(); b[W-1 -: M] = '0;
    run_op("R7 plain shift", 1'b1, 11'h3A5, b, rand_poly());
    chk("R7 shifted", poly_c, {b[W-M-1:0], {M{1'b0}}});

    b = rand_poly(); b[W-1 -: M] = 11'h001; g = rand_poly();
    run_op("R6 top one", 1'b1, '0, b, g);
    chk("R6 top one adds G", poly_c, {b[W-M-1:0], {M{1'b0}}} ^ g);

    b = rand_poly(); b[W-1 -: M] = 11'h7FF;
    run_op("R6 top max", 1'b1, '0, b, rand_poly());
    run_op("R2 max scalar", 1'b0, 11'h7FF, {T{11'h7FF}}, rand_poly());

    for (int n = 0; n < 60; n++) begin
      logic m;
      m = 1'($urandom() % 2);
      run_op(m ? "R6 random shift" : "R2 random scale", m, M'($urandom() % 2048),
             rand_poly(), rand_poly());
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule